// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects eight interrupt request lines from peripherals and presents a single interrupt line to a processor. Each line passes through a software-written enable register. Among the lines that are both latched and enabled, the lowest-numbered line wins. When the processor acknowledges, the controller returns an 8-bit vector and marks that line as in service. The vector is a programmable 5-bit base placed above the 3-bit line index.

The controller keeps one in-service bit per line, so service routines can nest. A request that outranks every line in service raises the interrupt output again, and that request pre-empts the current routine. A request at or below the highest in-service level is held until end-of-service commands have unwound the levels above it. The held requests are then offered in priority order. Software reaches the enable register, the vector base and the end-of-service command through a small write-only register port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `intOut` and `vecValid` are low, no line is in service, no request is latched, the vector base is 0 and every line is blocked by the enable register (enable value 0x00).
- R2: A write to address 0 loads the enable register from `regWrData[7:0]`, where bit i set lets line i through. A latched request on a blocked line never raises `intOut`. When its enable bit is later set, it raises `intOut` one cycle after that write.
- R3: An `irqIn` bit that is high at a rising clock edge is latched as pending and stays latched after the line drops, until that line is acknowledged. `intOut` reflects the new request right after that edge.
- R4: Line 0 has the highest priority and line 7 the lowest. An acknowledge grants the lowest-numbered enabled pending line.
- R5: A write to address 1 loads the vector base from `regWrData[4:0]`. On the clock edge that samples an honoured acknowledge, `vecOut` becomes {base, 3-bit line index} and `vecValid` is high for exactly one cycle.
- R6: An honoured acknowledge sets the in-service bit of the granted line and clears its pending bit. `intOut` then falls unless another request outranks that line.
- R7: `intOut` is high whenever an enabled pending line has a strictly lower index than every in-service line, even while another line is in service.
- R8: An enabled pending line whose index is equal to or greater than the lowest in-service index does not raise `intOut`. In particular, nothing raises it while line 0 is in service.
- R9: A write to address 2 (data ignored) is an end-of-service command. It clears the lowest-indexed in-service bit, after which held requests are offered again in priority order.
- R10: An acknowledge while `intOut` is low is ignored: `vecValid` stays low and the in-service state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| irqIn | input | 8 | Request lines, one per source, sampled each edge |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 enable, 1 vector base, 2 end-of-service |
| regWrData | input | 8 | Register write data |
| ackIn | input | 1 | Processor acknowledge, one cycle per acknowledge |
| intOut | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Vector of the last granted line |
| vecValid | output | 1 | One-cycle pulse marking a fresh vector |

## Verification
All of the block's state sits in registers, and `intOut` is a pure function of that state. Every stimulus therefore shows its effect one edge later. A request, enable write or end-of-service command applied before edge N changes `intOut` right after edge N. An acknowledge sampled at edge N gives `vecValid` and `vecOut` right after edge N and drops `intOut` at the same point. The bench applies each stimulus on a falling edge and compares outputs on the following falling edge, exactly one rising edge later. It holds other inputs idle in between, so no result has to be sampled at the edge where it changes.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  // Register port addresses
  localparam logic [1:0] ADDR_ENABLE = 2'd0;
  localparam logic [1:0] ADDR_BASE   = 2'd1;
  localparam logic [1:0] ADDR_EOS    = 2'd2;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrEnable;
    logic wrBase;
    logic endSvc;
    logic grant;
  } ctrlStrobes_t;

endpackage

// File: rtl/prio_irq_ctrl_seq.sv
module prio_irq_ctrl_seq
  import prio_irq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              ackIn,
  input  logic              intOut,
  output ctrlStrobes_t      strb
);

  always_comb begin
    strb          = '0;
    strb.wrEnable = regWr && (regAddr == ADDR_W'(ADDR_ENABLE));
    strb.wrBase   = regWr && (regAddr == ADDR_W'(ADDR_BASE));
    strb.endSvc   = regWr && (regAddr == ADDR_W'(ADDR_EOS));
    // acknowledge honoured only while a request is being signalled
    strb.grant    = ackIn && intOut;
  end

endmodule

// File: rtl/prio_irq_ctrl_path.sv
module prio_irq_ctrl_path
  import prio_irq_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int VEC_W     = 8,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic [DATA_W-1:0]    wrData,
  input  ctrlStrobes_t         strb,
  output logic                 intOut,
  output logic [VEC_W-1:0]     vecOut,
  output logic                 vecValid,
  output logic [NUM_LINES-1:0] pendQ,
  output logic [NUM_LINES-1:0] enQ,
  output logic [NUM_LINES-1:0] isrQ
);

  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int BASE_W = VEC_W - IDX_W;

  logic [BASE_W-1:0]    baseQ;
  logic [NUM_LINES-1:0] eligible;
  logic [IDX_W-1:0]     reqIdx, isrIdx;
  logic                 reqAny, isrAny;
  logic [NUM_LINES-1:0] grantHot, endHot;

  assign eligible = pendQ & enQ;

  // Fixed-priority encoders: lowest index wins
  always_comb begin
    reqIdx = '0;
    reqAny = 1'b0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        reqAny = 1'b1;
        reqIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    isrIdx = '0;
    isrAny = 1'b0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (isrQ[i]) begin
        isrAny = 1'b1;
        isrIdx = IDX_W'(i);
      end
    end
  end

  assign intOut = reqAny && (!isrAny || (reqIdx < isrIdx));

  // Per-line one-hot update terms
  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    assign grantHot[g] = strb.grant  && (reqIdx == IDX_W'(g));
    assign endHot[g]   = strb.endSvc && isrAny && (isrIdx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ    <= '0;
      isrQ     <= '0;
      enQ      <= '0;
      baseQ    <= '0;
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      pendQ    <= (pendQ | irqIn) & ~grantHot;
      isrQ     <= (isrQ & ~endHot) | grantHot;
      vecValid <= strb.grant;
      if (strb.wrEnable) enQ   <= wrData[NUM_LINES-1:0];
      if (strb.wrBase)   baseQ <= wrData[BASE_W-1:0];
      if (strb.grant)    vecOut <= {baseQ, reqIdx};
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int VEC_W     = 8,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 regWr,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic                 ackIn,
  output logic                 intOut,
  output logic [VEC_W-1:0]     vecOut,
  output logic                 vecValid
);

  ctrlStrobes_t         strb;
  logic [NUM_LINES-1:0] pendQ, enQ, isrQ;

  prio_irq_ctrl_seq #(.ADDR_W(ADDR_W)) uSeq (
    .regWr  (regWr),
    .regAddr(regAddr),
    .ackIn  (ackIn),
    .intOut (intOut),
    .strb   (strb)
  );

  prio_irq_ctrl_path #(
    .NUM_LINES(NUM_LINES),
    .VEC_W    (VEC_W),
    .DATA_W   (DATA_W)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .irqIn   (irqIn),
    .wrData  (regWrData),
    .strb    (strb),
    .intOut  (intOut),
    .vecOut  (vecOut),
    .vecValid(vecValid),
    .pendQ   (pendQ),
    .enQ     (enQ),
    .isrQ    (isrQ)
  );

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NUM_LINES = 8,
  parameter int VEC_W     = 8,
  parameter int ADDR_W    = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 ackIn,
  input logic                 regWr,
  input logic [ADDR_W-1:0]    regAddr,
  input logic                 intOut,
  input logic                 vecValid,
  input logic [VEC_W-1:0]     vecOut,
  input logic [NUM_LINES-1:0] enQ,
  input logic [NUM_LINES-1:0] pendQ,
  input logic [NUM_LINES-1:0] isrQ
);

  localparam int IDX_W = $clog2(NUM_LINES);

  logic eosWr;
  assign eosWr = regWr && (regAddr == ADDR_W'(2));

  p_blocked_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> (|(pendQ & enQ)));

  p_top_level_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    isrQ[0] |-> !intOut);

  p_vec_from_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(ackIn && intOut));

  p_vec_in_service_r6: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> isrQ[vecOut[IDX_W-1:0]]);

  p_eos_drops_one_r9: assert property (@(posedge clk) disable iff (!rstN)
    (eosWr && (|isrQ) && !(ackIn && intOut)) |=>
      ($countones(isrQ) + 1 == $countones($past(isrQ))));

  p_spurious_ack_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && !intOut && !eosWr) |=> (isrQ == $past(isrQ)) && !vecValid);

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .NUM_LINES(NUM_LINES),
  .VEC_W    (VEC_W),
  .ADDR_W   (ADDR_W)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .ackIn   (ackIn),
  .regWr   (regWr),
  .regAddr (regAddr),
  .intOut  (intOut),
  .vecValid(vecValid),
  .vecOut  (vecOut),
  .enQ     (enQ),
  .pendQ   (pendQ),
  .isrQ    (isrQ)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] irqIn;
  logic       regWr;
  logic [1:0] regAddr;
  logic [7:0] regWrData;
  logic       ackIn;
  logic       intOut;
  logic [7:0] vecOut;
  logic       vecValid;

  int errCnt = 0;
  int chkCnt = 0;

  always #10 clk = ~clk;  // 50 MHz

  prio_irq_ctrl uut (
    .clk      (clk),
    .rstN     (rstN),
    .irqIn    (irqIn),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .ackIn    (ackIn),
    .intOut   (intOut),
    .vecOut   (vecOut),
    .vecValid (vecValid)
  );

  // row: irq[29:22] ack[21] wr[20] addr[19:18] data[17:10] eInt[9] eVld[8] eVec[7:0]
  function automatic logic [29:0] mk(logic [7:0] irq, logic ack, logic wr,
                                     logic [1:0] a, logic [7:0] d,
                                     logic eInt, logic eVld, logic [7:0] eVec);
    return {irq, ack, wr, a, d, eInt, eVld, eVec};
  endfunction

  localparam int N = 28;
  localparam logic [29:0] TBL [N] = '{
    mk(8'h00,0,1,2'd0,8'hFF, 0,0,8'h00),  // 0  R2 enable all
    mk(8'h00,0,1,2'd1,8'h0A, 0,0,8'h00),  // 1  R5 base 0x0A
    mk(8'h20,0,0,2'd0,8'h00, 1,0,8'h00),  // 2  R3 line5 pulse
    mk(8'h00,1,0,2'd0,8'h00, 0,1,8'h55),  // 3  R6 grant line5
    mk(8'h80,0,0,2'd0,8'h00, 0,0,8'h00),  // 4  R8 line7 held
    mk(8'h04,0,0,2'd0,8'h00, 1,0,8'h00),  // 5  R7 line2 pre-empts
    mk(8'h00,1,0,2'd0,8'h00, 0,1,8'h52),  // 6  R7 grant line2
    mk(8'h08,0,0,2'd0,8'h00, 0,0,8'h00),  // 7  R8 line3 below 2
    mk(8'h00,0,1,2'd2,8'h00, 1,0,8'h00),  // 8  R9 end 2, line3 over 5
    mk(8'h00,1,0,2'd0,8'h00, 0,1,8'h53),  // 9  R9 grant line3
    mk(8'h00,0,1,2'd2,8'h00, 0,0,8'h00),  // 10 R9 end 3, back to 5
    mk(8'h00,0,1,2'd2,8'h00, 1,0,8'h00),  // 11 R9 end 5, line7 offered
    mk(8'h00,1,0,2'd0,8'h00, 0,1,8'h57),  // 12 R9 grant line7
    mk(8'h00,0,1,2'd2,8'h00, 0,0,8'h00),  // 13 R9 end 7
    mk(8'h00,1,0,2'd0,8'h00, 0,0,8'h00),  // 14 R10 spurious ack
    mk(8'h02,0,1,2'd0,8'h00, 0,0,8'h00),  // 15 R2 block all, line1
    mk(8'h00,0,0,2'd0,8'h00, 0,0,8'h00),  // 16 R2 still blocked
    mk(8'h00,0,1,2'd0,8'h02, 1,0,8'h00),  // 17 R2 enable line1
    mk(8'h00,1,0,2'd0,8'h00, 0,1,8'h51),  // 18 R4 grant line1
    mk(8'h00,0,1,2'd2,8'h00, 0,0,8'h00),  // 19 R9 end 1
    mk(8'h00,0,1,2'd0,8'hFF, 0,0,8'h00),  // 20 R2 enable all
    mk(8'h92,0,0,2'd0,8'h00, 1,0,8'h00),  // 21 R4 lines 1,4,7 together
    mk(8'h00,1,0,2'd0,8'h00, 0,1,8'h51),  // 22 R4 line1 first
    mk(8'h00,0,1,2'd2,8'h00, 1,0,8'h00),  // 23 R9 end 1
    mk(8'h00,1,0,2'd0,8'h00, 0,1,8'h54),  // 24 R4 line4 next
    mk(8'h00,0,1,2'd2,8'h00, 1,0,8'h00),  // 25 R9 end 4
    mk(8'h00,1,0,2'd0,8'h00, 0,1,8'h57),  // 26 R4 line7 last
    mk(8'h00,0,1,2'd2,8'h00, 0,0,8'h00)   // 27 R9 end 7
  };

  function automatic string reqOf(int s);
    case (s)
      0, 15, 16, 17, 20:                return "R2";
      1:                                return "R5";
      2:                                return "R3";
      3:                                return "R6";
      4, 7:                             return "R8";
      5, 6:                             return "R7";
      14:                               return "R10";
      18, 21, 22, 24, 26:               return "R4";
      default:                          return "R9";
    endcase
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idleInputs();
    irqIn = '0; ackIn = 1'b0; regWr = 1'b0; regAddr = '0; regWrData = '0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    chkCnt++;
    errCnt++;
    $display("FAIL watchdog: actual=hung expected=done");
    finishRun();
  end

  initial begin
    rstN = 1'b0;
    idleInputs();
    repeat (2) @(negedge clk);
    // R1 outputs in reset
    check("R1", "intOut", {7'd0, intOut}, 8'h00);
    check("R1", "vecValid", {7'd0, vecValid}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    for (int s = 0; s < N; s++) begin
      irqIn     = TBL[s][29:22];
      ackIn     = TBL[s][21];
      regWr     = TBL[s][20];
      regAddr   = TBL[s][19:18];
      regWrData = TBL[s][17:10];
      @(negedge clk);
      check(reqOf(s), "intOut", {7'd0, intOut}, {7'd0, TBL[s][9]});
      check(reqOf(s), "vecValid", {7'd0, vecValid}, {7'd0, TBL[s][8]});
      if (TBL[s][8]) check(reqOf(s), "vecOut", vecOut, TBL[s][7:0]);
      idleInputs();
      @(negedge clk);
      // R5 vecValid is a single-cycle pulse
      check("R5", "vecValid pulse", {7'd0, vecValid}, 8'h00);
    end

    // Second reset: base and enable return to defaults (R1)
    rstN = 1'b0;
    @(negedge clk);
    check("R1", "intOut", {7'd0, intOut}, 8'h00);
    rstN = 1'b1;
    irqIn = 8'h40;  // line6, blocked by reset enable value
    @(negedge clk);
    idleInputs();
    check("R1", "intOut blocked", {7'd0, intOut}, 8'h00);
    @(negedge clk);
    check("R3", "intOut still low", {7'd0, intOut}, 8'h00);
    regWr = 1'b1; regAddr = 2'd0; regWrData = 8'hFF;
    @(negedge clk);
    idleInputs();
    check("R3", "latched line6 raises", {7'd0, intOut}, 8'h01);
    ackIn = 1'b1;
    @(negedge clk);
    idleInputs();
    check("R5", "vecValid", {7'd0, vecValid}, 8'h01);
    check("R1", "vecOut base 0", vecOut, 8'h06);
    check("R6", "intOut after grant", {7'd0, intOut}, 8'h00);
    ackIn = 1'b1;  // spurious, nothing pending
    @(negedge clk);
    idleInputs();
    check("R10", "vecValid", {7'd0, vecValid}, 8'h00);
    irqIn = 8'h01;  // line0 pre-empts line6
    @(negedge clk);
    idleInputs();
    check("R7", "line0 over line6", {7'd0, intOut}, 8'h01);
    ackIn = 1'b1;
    @(negedge clk);
    idleInputs();
    check("R4", "vecOut line0", vecOut, 8'h00);
    irqIn = 8'h01;  // line0 again while line0 in service
    @(negedge clk);
    idleInputs();
    check("R8", "equal level held", {7'd0, intOut}, 8'h00);
    regWr = 1'b1; regAddr = 2'd2;
    @(negedge clk);
    idleInputs();
    check("R9", "line0 offered after end", {7'd0, intOut}, 8'h01);

    finishRun();
  end

endmodule